// File: doc/BRIEF.md
# Asynchronous SRAM Controller

This block sits between an on-chip requester and one external byte-wide asynchronous static RAM. It takes one read or write per request, drives the memory's address, active-low chip select, write enable and output enable, and times every phase in whole system-clock cycles. Each minimum or maximum delay is given in nanoseconds together with the clock period. The block turns each delay into a cycle count by ceiling division, so changing speed grade or clock rate means changing parameters only.

The data bus is shared by both directions. It appears at the block's edge as three plain signals: an output value, an output-drive enable and an input value. The pad ring builds the tristate from these. A write drives the bus only while the memory cannot drive it. A read keeps the controller's drivers off. After a read, an idle gap covers the memory's output float time before any later cycle may begin.

Requests use a valid/ready handshake. A request is taken on a rising clock edge where `req_valid` and `req_ready` are both high. `req_ready` stays low from then until the cycle has fully finished, including any turnaround. While `req_ready` is low, the requester must hold its request. Read data comes back as a one-cycle `rsp_valid` pulse with no back-pressure, so the requester must always be able to take it.

Top module: `asram_ctrl`

## Requirements
- R1: Out of reset and when idle, chip select, write enable and output enable are high (1), the bus drive enable is low and `req_ready` is high.
- R2: A request is accepted only on an edge where `req_valid` and `req_ready` are both high. `req_ready` is low while chip select is low and until the cycle, including turnaround, is over. Each acceptance produces exactly one memory cycle.
- R3: Every delay parameter becomes cycles as ceil(ns / CLK_PERIOD_NS), and any non-zero delay gives at least one cycle.
- R4: During a write, chip select and write enable fall on the same edge and output enable stays high. Write enable stays low for max(write pulse, address-to-end-of-write, data setup) cycles, with address and data held constant.
- R5: The bus drive enable rises with the fall of write enable. It stays high through the first cycle after write enable rises and is low in the cycle after that. The memory latches the data present when write enable rises.
- R6: A write occupies max(write cycle time, pulse cycles + 1) cycles from acceptance until `req_ready` returns high.
- R7: During a read, write enable is high and the drive enable is low. Output enable is low for max(address access, output-enable access, read cycle time) cycles. Data is sampled on the edge that ends the last of those cycles.
- R8: Read data appears on `rsp_rdata` together with a single-cycle `rsp_valid` pulse in the cycle right after the sampling edge.
- R9: After a read, chip select and output enable stay high and `req_ready` stays low for the output-float count of cycles. No new cycle starts and the bus is not driven during that time.
- R10: The drive enable is never high while output enable is low. The memory's read condition (chip select low, write enable high, output enable low) never coincides with the controller driving the bus.
- R11: Without requests, chip select stays high; the block starts no cycle on its own.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | One-cycle read-data strobe |
| rsp_rdata | output | DATA_W | Read data |
| mem_addr | output | ADDR_W | Memory address pins |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_dq_out | output | DATA_W | Value driven onto the data bus |
| mem_dq_oe | output | 1 | Drive enable for the data bus |
| mem_dq_in | input | DATA_W | Value read from the data bus |

## Verification
The bench builds the controller with a 6-bit address and a 5 ns nominal clock period, while the default nanosecond limits stay in place. Under that setting, access takes 4 cycles, output-enable access 2 cycles, the write pulse 3 cycles and the float time 1 cycle, so every phase spans several cycles and an off-by-one in any count shows as a wrong latency. The 64-location space is small enough to write and read back every address. A memory model returns wrong data until its access counts have elapsed and tracks float time, so early sampling, short pulses and bus contention all show at the ports.

// File: rtl/asram_pkg.sv
package asram_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD,
    ST_WR,
    ST_WHOLD,
    ST_TURN
  } asram_state_e;

  // ceiling conversion; a non-zero delay always yields one cycle or more
  function automatic int unsigned ns2cyc(int unsigned ns, int unsigned period);
    if (ns == 0) return 0;
    return (ns + period - 1) / period;
  endfunction

  function automatic int unsigned max2(int unsigned a, int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/asram_timer.sv
module asram_timer #(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          last
);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt_q <= '0;
    else if (load)         cnt_q <= load_val;
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign last = (cnt_q == '0);

endmodule

// File: rtl/asram_fsm.sv
module asram_fsm
  import asram_pkg::*;
#(
  parameter int CW     = 4,
  parameter int RD_CYC = 2,
  parameter int WP_CYC = 2,
  parameter int WH_CYC = 1,
  parameter int TA_CYC = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic          cnt_last,
  output logic          cnt_load,
  output logic [CW-1:0] cnt_val,
  output logic          req_ready,
  output logic          accept,
  output logic          rd_sample,
  output logic          cs_n,
  output logic          we_n,
  output logic          oe_n,
  output logic          dq_oe
);

  localparam int TA_M1 = (TA_CYC > 0) ? TA_CYC - 1 : 0;
  localparam logic [CW-1:0] RD_LD = CW'(RD_CYC - 1);
  localparam logic [CW-1:0] WP_LD = CW'(WP_CYC - 1);
  localparam logic [CW-1:0] WH_LD = CW'(WH_CYC - 1);
  localparam logic [CW-1:0] TA_LD = CW'(TA_M1);

  asram_state_e st_q, st_d;

  always_comb begin
    st_d     = st_q;
    cnt_load = 1'b0;
    cnt_val  = '0;
    unique case (st_q)
      ST_IDLE: if (req_valid) begin
        st_d     = req_write ? ST_WR : ST_RD;
        cnt_load = 1'b1;
        cnt_val  = req_write ? WP_LD : RD_LD;
      end
      ST_RD: if (cnt_last) begin
        if (TA_CYC > 0) begin
          st_d     = ST_TURN;
          cnt_load = 1'b1;
          cnt_val  = TA_LD;
        end else begin
          st_d = ST_IDLE;
        end
      end
      ST_WR: if (cnt_last) begin
        st_d     = ST_WHOLD;
        cnt_load = 1'b1;
        cnt_val  = WH_LD;
      end
      ST_WHOLD: if (cnt_last) st_d = ST_IDLE;
      ST_TURN:  if (cnt_last) st_d = ST_IDLE;
      default:  st_d = ST_IDLE;
    endcase
  end

  assign req_ready = (st_q == ST_IDLE);
  assign accept    = req_ready && req_valid;
  assign rd_sample = (st_q == ST_RD) && cnt_last;

  // strobes are registered from the next state so the pins never glitch
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      cs_n  <= 1'b1;
      we_n  <= 1'b1;
      oe_n  <= 1'b1;
      dq_oe <= 1'b0;
    end else begin
      st_q  <= st_d;
      cs_n  <= !(st_d == ST_RD || st_d == ST_WR || st_d == ST_WHOLD);
      we_n  <= (st_d != ST_WR);
      oe_n  <= (st_d != ST_RD);
      dq_oe <= (st_d == ST_WR) || (st_q == ST_WR && st_d == ST_WHOLD);
    end
  end

  // R4: write enable and chip select fall together so the memory stays off the bus
  a_r4_cs_we_fall_together: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(we_n) |-> $fell(cs_n));

  // R7: a read never enables the controller's drivers
  a_r7_read_no_drive: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_RD) |-> (!dq_oe && we_n));

endmodule

// File: rtl/asram_datapath.sv
module asram_datapath #(
  parameter int ADDR_W = 19,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic              rd_sample,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [DATA_W-1:0] mem_dq_in,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_addr   <= '0;
      mem_dq_out <= '0;
    end else if (accept) begin
      mem_addr   <= req_addr;
      mem_dq_out <= req_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= rd_sample;
      if (rd_sample) rsp_rdata <= mem_dq_in;
    end
  end

  // R8: the response strobe lasts one cycle
  a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

endmodule

// File: rtl/asram_ctrl.sv
module asram_ctrl
  import asram_pkg::*;
#(
  parameter int ADDR_W        = 19,
  parameter int DATA_W        = 8,
  parameter int CLK_PERIOD_NS = 10,
  parameter int T_RC_NS       = 20,
  parameter int T_AA_NS       = 20,
  parameter int T_OE_NS       = 10,
  parameter int T_WC_NS       = 20,
  parameter int T_WP_NS       = 14,
  parameter int T_AW_NS       = 14,
  parameter int T_DW_NS       = 9,
  parameter int T_OHZ_NS      = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_cs_n,
  output logic              mem_we_n,
  output logic              mem_oe_n,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic              mem_dq_oe,
  input  logic [DATA_W-1:0] mem_dq_in
);

  localparam int C_RC  = ns2cyc(T_RC_NS,  CLK_PERIOD_NS);
  localparam int C_AA  = ns2cyc(T_AA_NS,  CLK_PERIOD_NS);
  localparam int C_OE  = ns2cyc(T_OE_NS,  CLK_PERIOD_NS);
  localparam int C_WC  = ns2cyc(T_WC_NS,  CLK_PERIOD_NS);
  localparam int C_WP  = ns2cyc(T_WP_NS,  CLK_PERIOD_NS);
  localparam int C_AW  = ns2cyc(T_AW_NS,  CLK_PERIOD_NS);
  localparam int C_DW  = ns2cyc(T_DW_NS,  CLK_PERIOD_NS);
  localparam int C_OHZ = ns2cyc(T_OHZ_NS, CLK_PERIOD_NS);

  localparam int RD_CYC = max2(1, max2(C_RC, max2(C_AA, C_OE)));
  localparam int WP_CYC = max2(1, max2(C_WP, max2(C_AW, C_DW)));
  localparam int WH_CYC = (C_WC > WP_CYC + 1) ? C_WC - WP_CYC : 1;
  localparam int TA_CYC = C_OHZ;
  localparam int MAXC   = max2(max2(RD_CYC, WP_CYC), max2(WH_CYC, TA_CYC));
  localparam int CW     = $clog2(MAXC + 1) + 1;

  logic          cnt_load, cnt_last, accept, rd_sample;
  logic [CW-1:0] cnt_val;

  asram_timer #(.CW(CW)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (cnt_load),
    .load_val (cnt_val),
    .last     (cnt_last)
  );

  asram_fsm #(
    .CW     (CW),
    .RD_CYC (RD_CYC),
    .WP_CYC (WP_CYC),
    .WH_CYC (WH_CYC),
    .TA_CYC (TA_CYC)
  ) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_write (req_write),
    .cnt_last  (cnt_last),
    .cnt_load  (cnt_load),
    .cnt_val   (cnt_val),
    .req_ready (req_ready),
    .accept    (accept),
    .rd_sample (rd_sample),
    .cs_n      (mem_cs_n),
    .we_n      (mem_we_n),
    .oe_n      (mem_oe_n),
    .dq_oe     (mem_dq_oe)
  );

  asram_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk        (clk),
    .rst_n      (rst_n),
    .accept     (accept),
    .rd_sample  (rd_sample),
    .req_addr   (req_addr),
    .req_wdata  (req_wdata),
    .mem_dq_in  (mem_dq_in),
    .mem_addr   (mem_addr),
    .mem_dq_out (mem_dq_out),
    .rsp_valid  (rsp_valid),
    .rsp_rdata  (rsp_rdata)
  );

  // R10: controller drive and memory output enable are exclusive
  a_r10_no_contention: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> mem_oe_n);

  // R4: write enable low implies selected with outputs disabled
  a_r4_write_strobes: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> (!mem_cs_n && mem_oe_n));

  // R2: no acceptance while a memory cycle is active
  a_r2_busy_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_cs_n |-> !req_ready);

  // R5: data is still driven in the cycle write enable rises
  a_r5_drive_past_we: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(mem_we_n) && mem_we_n) |-> mem_dq_oe);

  // R5: no drive after the hold cycle
  a_r5_release: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_dq_oe && mem_we_n) |=> !mem_dq_oe);

  generate
    if (TA_CYC > 0) begin : g_turn_chk
      // R9: the float gap follows every read
      a_r9_turnaround: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(mem_oe_n) && mem_oe_n) |-> (!req_ready && !mem_dq_oe));
    end
  endgenerate

endmodule

// File: tb/sim_asram_ctrl.sv
module sim_asram_ctrl;

  localparam int AW  = 6;
  localparam int DW  = 8;
  localparam int PER = 5;
  localparam int N   = 1 << AW;
  // expected counts derived from the requirements (R3)
  localparam int AA_E  = (20 + PER - 1) / PER;  // 4
  localparam int OE_E  = (10 + PER - 1) / PER;  // 2
  localparam int RD_E  = 4;                     // max(4,2,4)
  localparam int WP_E  = 3;                     // max(ceil 14/5, ceil 14/5, ceil 9/5)
  localparam int WR_E  = 4;                     // max(ceil 20/5, 3+1)
  localparam int OHZ_E = 1;                     // ceil 5/5

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic req_ready, rsp_valid, mem_cs_n, mem_we_n, mem_oe_n, mem_dq_oe;
  logic [DW-1:0] rsp_rdata, mem_dq_out, mem_dq_in;
  logic [AW-1:0] mem_addr;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  always #10 clk = ~clk;

  asram_ctrl #(.ADDR_W(AW), .DATA_W(DW), .CLK_PERIOD_NS(PER)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .mem_addr(mem_addr),
    .mem_cs_n(mem_cs_n), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
    .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  // memory model: wrong data until access counts elapse
  logic [DW-1:0] mem [N];
  logic [AW-1:0] last_addr = '0;
  int addr_age = 0, oe_age = 0, oe_hi_age = 0, wlow = 0;
  bit post_hold = 0;
  wire rd_cond = !mem_cs_n && mem_we_n && !mem_oe_n;
  assign mem_dq_in = (rd_cond && addr_age >= AA_E && oe_age >= OE_E) ?
                     mem[mem_addr] : ~mem[mem_addr];

  always @(posedge clk) cyc++;

  always @(negedge clk) if (rst_n) begin
    addr_age  = mem_cs_n ? 0 : ((mem_addr == last_addr && addr_age > 0) ? addr_age + 1 : 1);
    last_addr = mem_addr;
    oe_age    = (!mem_cs_n && !mem_oe_n) ? oe_age + 1 : 0;
    oe_hi_age = mem_oe_n ? ((oe_hi_age < 100) ? oe_hi_age + 1 : oe_hi_age) : 0;
    if (mem_dq_oe && rd_cond) chk(0, "R10 contention", 1, 0);
    if (mem_dq_oe) chk(oe_hi_age > OHZ_E, "R9 float gap", oe_hi_age, OHZ_E + 1);
    if (!mem_cs_n && !mem_we_n) begin
      wlow++;
      chk(mem_oe_n && mem_dq_oe, "R4 oe high and data driven in pulse", {mem_oe_n, mem_dq_oe}, 3);
    end else if (wlow > 0) begin
      chk(wlow == WP_E, "R4 write pulse cycles", wlow, WP_E);
      chk(mem_dq_oe == 1'b1, "R5 drive in cycle after we rise", mem_dq_oe, 1);
      mem[mem_addr] = mem_dq_out;
      wlow = 0;
      post_hold = 1;
    end else if (post_hold) begin
      chk(mem_dq_oe == 1'b0, "R5 release after hold", mem_dq_oe, 0);
      post_hold = 0;
    end
  end

  task automatic do_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
    int k;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1; req_write = 1; req_addr = a; req_wdata = d;
    @(posedge clk);
    @(negedge clk);
    req_valid = 0;
    k = 1;
    chk(!req_ready, "R2 ready low while busy", req_ready, 0);
    while (!req_ready && k < 50) begin @(negedge clk); if (!req_ready) k++; end
    chk(k == WR_E, "R6 write occupancy", k, WR_E);
  endtask

  task automatic do_read(input logic [AW-1:0] a, input logic [DW-1:0] exp);
    int k;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1; req_write = 0; req_addr = a;
    @(posedge clk);
    @(negedge clk);
    req_valid = 0;
    k = 0;
    while (!rsp_valid && k < 50) begin
      chk(!req_ready && mem_we_n && !mem_dq_oe, "R7 read phase strobes",
          {req_ready, mem_we_n, mem_dq_oe}, 2);
      k++;
      @(negedge clk);
    end
    chk(k == RD_E, "R7 read latency", k, RD_E);
    chk(rsp_rdata == exp, "R8 read data", rsp_rdata, exp);
    chk(!req_ready && mem_cs_n && mem_oe_n, "R9 turnaround idle",
        {req_ready, mem_cs_n, mem_oe_n}, 3);
    @(negedge clk);
    chk(!rsp_valid, "R8 single pulse", rsp_valid, 0);
    chk(req_ready, "R9 ready after float count", req_ready, 1);
  endtask

  initial begin
    for (int i = 0; i < N; i++) mem[i] = 8'h00;
    repeat (3) @(negedge clk);
    chk(mem_cs_n && mem_we_n && mem_oe_n && !mem_dq_oe && req_ready,
        "R1 reset state", {mem_cs_n, mem_we_n, mem_oe_n, mem_dq_oe, req_ready}, 29);
    rst_n = 1;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      chk(mem_cs_n && !rsp_valid, "R11 idle keeps deselected", mem_cs_n, 1);
    end
    // R3 sweep: write every address, then read all back
    for (int a = 0; a < N; a++) do_write(AW'(a), DW'(a * 37 + 5));
    for (int a = 0; a < N; a++) do_read(AW'(a), DW'(a * 37 + 5));
    // alternating write/read with a second pattern, descending order
    for (int a = N - 1; a >= 0; a--) begin
      do_write(AW'(a), DW'(a ^ 8'hC3));
      do_read(AW'(a), DW'(a ^ 8'hC3));
    end
    // back-to-back reads of neighbours
    for (int a = 0; a < 8; a++) do_read(AW'(a), DW'(a ^ 8'hC3));
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      chk(mem_cs_n && req_ready, "R1 idle after traffic", {mem_cs_n, req_ready}, 3);
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  always @(posedge clk) if (cyc > 100000) begin
    checks++;
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 100000);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule